// File: doc/BRIEF.md
# Serial Character Transmitter with Queue and Line Break

This block turns bytes written by a host into asynchronous serial frames. Written characters wait in a first-in first-out queue of `DEPTH` entries. Whenever the shifter is idle and the queue holds a character, the shifter takes the oldest one. It then sends a low start bit, followed by 5 to 8 data bits with the least significant bit first. An optional parity bit comes next, and the frame ends with a high stop period. Timing comes from an external enable that pulses sixteen times per bit period.

Two status outputs report the transmit side. One says the queue is empty. The other says both the queue and the shifter are empty. A flush input empties the queue but lets the character already in the shifter finish. A break input holds the line low, and the shifter keeps running underneath it.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset the line `txd` is high and both `thr_empty` and `tx_empty` are 1.
- R2: A frame is a start bit (0), then `word_len`+5 data bits sent least significant bit first (`word_len` 0..3 selects 5..8 bits), then the stop period (1). Each bit lasts 16 `baud_tick` pulses. The shifter loads the oldest queued character in the first clock in which it is idle, the queue is not empty and `flush` is low.
- R3: With `par_en`=1, a parity bit follows the data. With `par_even`=1 it makes the count of ones in data plus parity even; with `par_even`=0 it makes that count odd.
- R4: With `par_en`=1 and `par_stick`=1, the parity bit is the constant `~par_even`.
- R5: With `stop_sel`=0 the stop period is 16 ticks. With `stop_sel`=1 it is 24 ticks for 5-bit characters and 32 ticks otherwise.
- R6: `thr_empty` is 1 exactly when the queue holds no character. `tx_empty` is 1 exactly when the queue is empty and no frame is in progress.
- R7: Characters leave in the order they were written. A write while the queue holds `DEPTH` characters is dropped, unless the shifter takes a character in that same clock, in which case the write is kept.
- R8: `flush` discards every queued character and leaves the frame in progress running to its end. A write in the same clock as `flush` becomes the only queued character.
- R9: While `brk` is 1, `txd` is 0. Bit timing and shifting go on unchanged beneath the break.
- R10: The frame format inputs are sampled when a character is loaded into the shifter. Changing them during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One pulse per sixteenth of a bit period |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | DW | Character to queue |
| flush | input | 1 | Discard queued characters |
| word_len | input | 2 | Data bits minus five |
| stop_sel | input | 1 | Long stop period select |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Constant parity select |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output |
| thr_empty | output | 1 | Queue empty |
| tx_empty | output | 1 | Queue and shifter both empty |

## Verification
Two pairs of events can fall in the same clock. The first pair is a write to a full queue and the shifter taking a character. The bench provokes it by filling the queue while a frame runs and then writing on every clock until that frame ends. Exactly one of those writes, the one in the load clock, must survive, and the remaining frames are judged against the reference queue. The second pair is a flush together with a write: the bench then expects that single character to be sent once the running frame finishes.

// File: rtl/serial_tx_engine.sv
module serial_tx_engine #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          flush,
  input  logic [1:0]    word_len,
  input  logic          stop_sel,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          par_stick,
  input  logic          brk,
  output logic          txd,
  output logic          thr_empty,
  output logic          tx_empty
);

  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int SW  = DW + 2;
  localparam int BCW = $clog2(SW + 1);

  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  rd_ptr, wr_ptr;
  logic [CW-1:0]  count;
  logic           busy;
  logic [SW-1:0]  sh, sh_new;
  logic [BCW-1:0] bit_cnt, frame_len;
  logic [5:0]     tcnt, stop_lim, cur_lim, stop_ticks;
  logic           pop, push, par_bit;
  logic [DW-1:0]  head, dmasked;
  int             nb;

  assign pop  = !busy && (count != '0) && !flush;
  assign push = wr_en && !flush && ((count != CW'(DEPTH)) || pop);
  assign head = mem[rd_ptr];
  assign nb   = 5 + int'(word_len);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= wr_en ? AW'(1) : '0;
      count  <= wr_en ? CW'(1) : '0;
    end else begin
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push) wr_ptr <= nxt(wr_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (flush && wr_en) mem[0] <= wr_data;
    else if (push)      mem[wr_ptr] <= wr_data;
  end

  always_comb begin
    for (int i = 0; i < DW; i++) dmasked[i] = (i < nb) ? head[i] : 1'b0;
    par_bit = par_stick ? ~par_even : (par_even ? ^dmasked : ~^dmasked);
    sh_new = '1;
    sh_new[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i < nb) sh_new[i+1] = head[i];
    if (par_en) sh_new[nb+1] = par_bit;
    frame_len  = BCW'(1 + nb + int'(par_en));
    stop_ticks = !stop_sel ? 6'd16 : (word_len == 2'd0 ? 6'd24 : 6'd32);
  end

  assign cur_lim = (bit_cnt != '0) ? 6'd15 : stop_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sh       <= '1;
      bit_cnt  <= '0;
      tcnt     <= '0;
      stop_lim <= '0;
    end else if (pop) begin
      busy     <= 1'b1;
      sh       <= sh_new;
      bit_cnt  <= frame_len;
      tcnt     <= '0;
      stop_lim <= stop_ticks - 6'd1;
    end else if (busy && baud_tick) begin
      if (tcnt == cur_lim) begin
        tcnt <= '0;
        if (bit_cnt != '0) begin
          sh      <= {1'b1, sh[SW-1:1]};
          bit_cnt <= bit_cnt - BCW'(1);
        end else begin
          busy <= 1'b0;
        end
      end else begin
        tcnt <= tcnt + 6'd1;
      end
    end
  end

  assign txd       = ~brk & ((busy && bit_cnt != '0) ? sh[0] : 1'b1);
  assign thr_empty = (count == '0);
  assign tx_empty  = thr_empty && !busy;

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R9
  break_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && brk && baud_tick && bit_cnt != '0 && tcnt == 6'd15) |=>
      (bit_cnt == $past(bit_cnt) - BCW'(1)));

  // R6
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |=> !busy);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wr_en) |=> thr_empty);

  // R8
  flush_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && busy && !baud_tick) |=> busy);

endmodule

// File: tb/serial_tx_engine_tb.sv
`timescale 1ns/100ps
module serial_tx_engine_tb;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0, baud_tick = 0, wr_en = 0, flush = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] word_len = 2'd3;
  logic stop_sel = 0, par_en = 0, par_even = 0, par_stick = 0, brk = 0;
  logic txd, thr_empty, tx_empty;

  int checks = 0, errors = 0, div = 1, dcnt = 0;
  bit done = 0;
  string cur_req = "R2";

  logic [7:0] q[$];
  bit lv[$];
  bit m_busy = 0;

  always #2.5 clk = ~clk;

  serial_tx_engine #(.DEPTH(DEPTH), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .flush(flush), .word_len(word_len), .stop_sel(stop_sel),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick), .brk(brk),
    .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty));

  always @(negedge clk) begin
    if (dcnt >= div - 1) begin baud_tick <= 1; dcnt <= 0; end
    else begin baud_tick <= 0; dcnt <= dcnt + 1; end
  end

  task automatic push_lv(bit b, int n);
    for (int i = 0; i < n; i++) lv.push_back(b);
  endtask

  task automatic m_load(logic [7:0] d);
    int n;
    bit p;
    n = 5 + int'(word_len);
    lv.delete();
    push_lv(0, 16);
    p = 0;
    for (int i = 0; i < n; i++) begin push_lv(d[i], 16); p ^= d[i]; end
    if (par_en) push_lv(par_stick ? ~par_even : (par_even ? p : ~p), 16);
    push_lv(1, !stop_sel ? 16 : (word_len == 0 ? 24 : 32));
    m_busy = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); lv.delete(); m_busy = 0;
    end else begin
      if (m_busy) begin
        if (baud_tick) begin
          void'(lv.pop_front());
          if (lv.size() == 0) m_busy = 0;
        end
      end else if (q.size() != 0 && !flush) begin
        m_load(q.pop_front());
      end
      if (flush) begin
        q.delete();
        if (wr_en) q.push_back(wr_data);
      end else if (wr_en && q.size() < DEPTH) q.push_back(wr_data);
    end
    #1.5;
    if (rst_n && !done) begin
      compare_bit(cur_req, "txd", txd, brk ? 1'b0 : (m_busy ? lv[0] : 1'b1));
      compare_bit("R6", "thr_empty", thr_empty, q.size() == 0);
      compare_bit("R6", "tx_empty", tx_empty, q.size() == 0 && !m_busy);
    end
  end

  task automatic compare_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic write(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (!(tx_empty && !m_busy) && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic fmt(logic [1:0] wl, logic st, logic pe, logic ev, logic sk);
    word_len = wl; stop_sel = st; par_en = pe; par_even = ev; par_stick = sk;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    compare_bit("R1", "txd", txd, 1);
    compare_bit("R1", "thr_empty", thr_empty, 1);
    compare_bit("R1", "tx_empty", tx_empty, 1);

    cur_req = "R2";
    fmt(2'd3, 0, 0, 0, 0);
    write(8'h55); write(8'hA3); wait_idle();
    for (int w = 0; w < 3; w++) begin
      fmt(w[1:0], 0, 0, 0, 0); write(8'h61); wait_idle();
    end

    cur_req = "R3";
    fmt(2'd2, 0, 1, 1, 0); write(8'h61); write(8'h07); wait_idle();
    fmt(2'd2, 0, 1, 0, 0); write(8'h61); write(8'h07); wait_idle();

    cur_req = "R4";
    fmt(2'd3, 0, 1, 0, 1); write(8'hFF); wait_idle();
    fmt(2'd3, 0, 1, 1, 1); write(8'h00); wait_idle();

    cur_req = "R5";
    fmt(2'd0, 1, 0, 0, 0); write(8'h15); write(8'h0A); wait_idle();
    fmt(2'd3, 1, 0, 0, 0); write(8'h3C); write(8'hC3); wait_idle();

    cur_req = "R6";
    div = 3;
    fmt(2'd3, 0, 0, 0, 0);
    write(8'h11);
    repeat (4) @(negedge clk);
    // R6: frame running, queue empty
    compare_bit("R6", "thr_empty busy", thr_empty, 1);
    compare_bit("R6", "tx_empty busy", tx_empty, 0);
    wait_idle();

    cur_req = "R7";
    div = 1;
    write(8'h80);
    for (int i = 0; i < DEPTH; i++) write(8'(8'h20 + i));
    // R7: queue full while the first character shifts
    compare_bit("R7", "thr_empty full", thr_empty, 0);
    @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      wr_en = 1; wr_data = 8'(8'h90 + i); @(negedge clk);
    end
    wr_en = 0;
    wait_idle();

    cur_req = "R8";
    div = 2;
    @(negedge clk); wr_en = 1; wr_data = 8'h31;
    @(negedge clk); wr_data = 8'h32;
    @(negedge clk); wr_data = 8'h33;
    @(negedge clk); wr_en = 0;
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    // R8: queue gone, the character in flight continues
    compare_bit("R8", "thr_empty after flush", thr_empty, 1);
    compare_bit("R8", "tx_empty after flush", tx_empty, 0);
    write(8'h41); write(8'h42);
    @(negedge clk); flush = 1; wr_en = 1; wr_data = 8'h5A;
    @(negedge clk); flush = 0; wr_en = 0;
    // R8: write in the flush clock is kept
    compare_bit("R8", "thr_empty flush+write", thr_empty, 0);
    wait_idle();

    cur_req = "R9";
    div = 1;
    write(8'hF0);
    repeat (40) @(negedge clk);
    brk = 1;
    @(negedge clk);
    compare_bit("R9", "txd under break", txd, 0);
    repeat (50) @(negedge clk);
    brk = 0;
    wait_idle();
    brk = 1; repeat (20) @(negedge clk);
    compare_bit("R9", "tx_empty under idle break", tx_empty, 1);
    brk = 0;

    cur_req = "R10";
    fmt(2'd3, 0, 0, 0, 0);
    write(8'hB6); write(8'h6B);
    repeat (30) @(negedge clk);
    fmt(2'd0, 1, 1, 1, 0);
    wait_idle();

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule